// File: doc/BRIEF.md
# Configurable sum-of-products plane with NOR feedback term

This block is the combinational heart of a field-configurable logic sequencer. Sixteen literals feed an AND plane: four dedicated inputs, four bidirectional-pin inputs and eight register feedback bits. Each literal can be linked in true or inverted form. The plane forms 32 logic product terms and 13 control product terms. A single NOR gate, the feedback term, takes any chosen subset of those products. Its output can be linked, inverted only, back into every product. The logic products are ORed into 21 sums. The first four sums drive the pin outputs through a per-pin XOR polarity bit, so each pin can be AND-OR or AND-NOR. The remaining sums go to the register steering logic outside this block.

The whole link pattern is a single static configuration vector, `cfg_i`, held constant while the plane is in use. Control products are brought out unsummed. By convention, the lowest four control products serve as the asynchronous preset and reset terms of the registers. The block has no clock and no state.

Configuration layout: every product term `t` (0..44) owns 34 bits starting at `t*34`. Bits `2k` and `2k+1` are the true and inverted links of literal `k`. Bit 32 is the link to the inverted feedback term. Bit 33 makes the term an input of the NOR gate. Sum `s` owns 32 bits at `1530 + s*32`, one bit per logic term. Pin polarity bit `p` is at `2202 + p`.

Top module: `sop_plane`

## Requirements
- R1: A set true link for literal k (literal order: din 0..3, pin 4..7, fb 8..15; link bit t*34+2k) forces the product to 0 whenever that literal is 0.
- R2: A set inverted link for literal k (bit t*34+2k+1) forces the product to 0 whenever that literal is 1.
- R3: When both links of one literal are set, the product is 0 regardless of the inputs.
- R4: A product with no links set evaluates to 1; with an all-zero configuration every control output and the feedback term are 1 and every sum and pin output is 0.
- R5: Each sum s is the OR of the logic products whose bit 1530+s*32+t is set; a sum with no bits set is 0.
- R6: Pin output p equals sum p, inverted when polarity bit 2202+p is set.
- R7: `comp_o` is the NOR of all products whose bit 33 is set, and is 1 when no product has that bit set.
- R8: A product with bit 32 set, and bit 33 clear, is 0 whenever `comp_o` is 1.
- R9: Control products 32..44 appear on `ctrl_o[0..12]` and never contribute to any sum.
- R10: A product with both bit 32 and bit 33 set raises `cfg_err_o`; its feedback link is then ignored, so no combinational loop forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din_i | input | 4 | Dedicated inputs, literals 0..3 |
| pin_i | input | 4 | Bidirectional pin inputs, literals 4..7 |
| fb_i | input | 8 | Register feedback, literals 8..15 |
| cfg_i | input | 2206 | Static link pattern |
| sum_o | output | 21 | OR sums of logic products |
| pin_o | output | 4 | Pin sums after polarity XOR |
| ctrl_o | output | 13 | Control products |
| comp_o | output | 1 | Feedback NOR term |
| cfg_err_o | output | 1 | Feedback loop rule violated |

## Verification
Two functions can be active on the same evaluation. One is the detection of a feedback-loop configuration. The other is the ordinary evaluation of the offending product, now without its feedback link. The bench provokes this by making a product both a NOR input and a feedback user, then toggles the literal it depends on. It requires `cfg_err_o` high, and it requires the product, the NOR term and the sum to follow the literal as if the feedback link were clear. A separate case, with a legal member and user pair, checks that the feedback term propagates through one product into a sum in the same evaluation.

// File: rtl/sop_plane.sv
module sop_plane #(
  parameter int N_DIN   = 4,
  parameter int N_PIN   = 4,
  parameter int N_FB    = 8,
  parameter int N_LOGIC = 32,
  parameter int N_CTRL  = 13,
  parameter int N_SUM   = 21,
  localparam int N_LIT    = N_DIN + N_PIN + N_FB,
  localparam int N_TERM   = N_LOGIC + N_CTRL,
  localparam int TERM_W   = 2 * N_LIT + 2,
  localparam int SUM_BASE = N_TERM * TERM_W,
  localparam int POL_BASE = SUM_BASE + N_SUM * N_LOGIC,
  localparam int CFG_W    = POL_BASE + N_PIN
) (
  input  logic [N_DIN-1:0]  din_i,
  input  logic [N_PIN-1:0]  pin_i,
  input  logic [N_FB-1:0]   fb_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [N_SUM-1:0]  sum_o,
  output logic [N_PIN-1:0]  pin_o,
  output logic [N_CTRL-1:0] ctrl_o,
  output logic              comp_o,
  output logic              cfg_err_o
);

  logic [N_LIT-1:0]  lit;
  logic [N_TERM-1:0] raw, term, member, clink;

  assign lit = {fb_i, pin_i, din_i};

  function automatic logic and_term(input logic [2*N_LIT-1:0] links,
                                    input logic [N_LIT-1:0] l);
    logic r;
    r = 1'b1;
    for (int k = 0; k < N_LIT; k++) begin
      if (links[2*k] && !l[k])   r = 1'b0;
      if (links[2*k+1] && l[k])  r = 1'b0;
    end
    return r;
  endfunction

  genvar t, s;
  generate
    for (t = 0; t < N_TERM; t++) begin : g_term
      localparam int B = t * TERM_W;
      assign raw[t]    = and_term(cfg_i[B +: 2*N_LIT], lit);
      assign clink[t]  = cfg_i[B + 2*N_LIT];
      assign member[t] = cfg_i[B + 2*N_LIT + 1];
    end
    for (s = 0; s < N_SUM; s++) begin : g_sum
      assign sum_o[s] = |(term[N_LOGIC-1:0] & cfg_i[SUM_BASE + s*N_LOGIC +: N_LOGIC]);
    end
  endgenerate

  assign cfg_err_o = |(member & clink);
  assign comp_o    = ~|(raw & member);
  assign term      = raw & ~(clink & ~member & {N_TERM{comp_o}});
  assign pin_o     = sum_o[N_PIN-1:0] ^ cfg_i[POL_BASE +: N_PIN];
  assign ctrl_o    = term[N_TERM-1:N_LOGIC];

  always_comb begin
    for (int i = 0; i < N_TERM; i++) begin
      for (int k = 0; k < N_LIT; k++) begin
        // R3
        forced_term_chk: assert (!(cfg_i[i*TERM_W+2*k] && cfg_i[i*TERM_W+2*k+1]) || !term[i]);
      end
      // R4
      empty_term_chk: assert ((cfg_i[i*TERM_W +: 2*N_LIT+1] != '0) || term[i]);
      // R8
      fb_block_chk: assert (!(clink[i] && !member[i] && comp_o) || !term[i]);
      // R7
      nor_member_chk: assert (!(comp_o && member[i]) || !term[i]);
    end
    for (int j = 0; j < N_SUM; j++) begin
      // R5
      empty_sum_chk: assert ((cfg_i[SUM_BASE + j*N_LOGIC +: N_LOGIC] != '0) || !sum_o[j]);
    end
  end

endmodule

// File: tb/sop_plane_test.sv
module sop_plane_test;
  localparam int NT = 45, NL = 32, NS = 21, NP = 4, NLIT = 16, TW = 34;
  localparam int SB = NT * TW, PB = SB + NS * NL, CW = PB + NP;

  typedef struct {
    logic [NS-1:0] sum;
    logic [NP-1:0] pin;
    logic [12:0]   ctrl;
    logic          comp;
    logic          err;
    string         tag;
  } exp_t;

  logic clk = 0;
  always #2 clk = ~clk;

  logic [3:0] din;
  logic [3:0] pin;
  logic [7:0] fb;
  logic [CW-1:0] cfg, cfg_next;
  logic [NS-1:0] sum_o;
  logic [NP-1:0] pin_o;
  logic [12:0] ctrl_o;
  logic comp_o, err_o;
  int total = 0, bad = 0;
  exp_t q[$];

  sop_plane uut (.din_i(din), .pin_i(pin), .fb_i(fb), .cfg_i(cfg),
                 .sum_o(sum_o), .pin_o(pin_o), .ctrl_o(ctrl_o),
                 .comp_o(comp_o), .cfg_err_o(err_o));

  function automatic exp_t model(input logic [CW-1:0] c, input logic [15:0] l, input string tag);
    exp_t e;
    logic [NT-1:0] r, tm;
    logic fbk;
    for (int t = 0; t < NT; t++) begin
      r[t] = 1;
      for (int k = 0; k < NLIT; k++) begin
        if (c[t*TW+2*k] && c[t*TW+2*k+1]) r[t] = 0;
        else if (c[t*TW+2*k] && !l[k]) r[t] = 0;
        else if (c[t*TW+2*k+1] && l[k]) r[t] = 0;
      end
    end
    fbk = 1;
    e.err = 0;
    for (int t = 0; t < NT; t++) begin
      if (c[t*TW+33] && r[t]) fbk = 0;
      if (c[t*TW+33] && c[t*TW+32]) e.err = 1;
    end
    for (int t = 0; t < NT; t++)
      tm[t] = r[t] && !(c[t*TW+32] && !c[t*TW+33] && fbk);
    for (int s = 0; s < NS; s++) begin
      e.sum[s] = 0;
      for (int t = 0; t < NL; t++) if (c[SB+s*NL+t] && tm[t]) e.sum[s] = 1;
    end
    for (int p = 0; p < NP; p++) e.pin[p] = e.sum[p] ^ c[PB+p];
    e.ctrl = tm[NT-1:NL];
    e.comp = fbk;
    e.tag = tag;
    return e;
  endfunction

  task automatic apply(input logic [3:0] d, input logic [3:0] p, input logic [7:0] f, input string tag);
    @(posedge clk);
    cfg = cfg_next; din = d; pin = p; fb = f;
    q.push_back(model(cfg_next, {f, p, d}, tag));
  endtask

  task automatic lnk(input int t, input int k, input bit inv);
    cfg_next[t*TW + 2*k + inv] = 1'b1;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "sum", 32'(sum_o), 32'(e.sum));
      chk(e.tag, "pin", 32'(pin_o), 32'(e.pin));
      chk(e.tag, "ctrl", 32'(ctrl_o), 32'(e.ctrl));
      chk(e.tag, "comp", 32'(comp_o), 32'(e.comp));
      chk(e.tag, "err", 32'(err_o), 32'(e.err));
    end
  end

  task automatic run_all();
    // R4 all-zero configuration
    cfg_next = '0;
    apply(4'h0, 4'h0, 8'h00, "R4");
    apply(4'hf, 4'ha, 8'h5c, "R4");
    // R1 true link on din0 into sum 0
    cfg_next = '0; lnk(0, 0, 0); cfg_next[SB + 0*NL + 0] = 1;
    apply(4'h0, 4'h0, 8'h00, "R1");
    apply(4'h1, 4'h0, 8'h00, "R1");
    // R2 inverted link on fb3 (literal 11) into sum 1
    cfg_next = '0; lnk(1, 11, 1); cfg_next[SB + 1*NL + 1] = 1;
    apply(4'h0, 4'h0, 8'h08, "R2");
    apply(4'h0, 4'h0, 8'h00, "R2");
    // R3 both links on pin2 (literal 6)
    cfg_next = '0; lnk(2, 6, 0); lnk(2, 6, 1); cfg_next[SB + 2*NL + 2] = 1;
    apply(4'h0, 4'h0, 8'h00, "R3");
    apply(4'h0, 4'h4, 8'h00, "R3");
    // R5 two terms into sum 5
    cfg_next = '0; lnk(4, 1, 0); lnk(5, 2, 0);
    cfg_next[SB + 5*NL + 4] = 1; cfg_next[SB + 5*NL + 5] = 1;
    apply(4'h0, 4'h0, 8'h00, "R5");
    apply(4'h2, 4'h0, 8'h00, "R5");
    apply(4'h4, 4'h0, 8'h00, "R5");
    // R6 polarity on pin 3 with empty sum, and on pin 0 with live sum
    cfg_next = '0; cfg_next[PB + 3] = 1; cfg_next[PB + 0] = 1;
    lnk(0, 3, 0); cfg_next[SB + 0] = 1;
    apply(4'h0, 4'h0, 8'h00, "R6");
    apply(4'h8, 4'h0, 8'h00, "R6");
    // R7 and R8 legal feedback pair
    cfg_next = '0; lnk(6, 3, 0); cfg_next[6*TW + 33] = 1;
    cfg_next[7*TW + 32] = 1; cfg_next[SB + 6*NL + 7] = 1;
    apply(4'h8, 4'h0, 8'h00, "R7");
    apply(4'h0, 4'h0, 8'h00, "R8");
    // R9 control term and no sum contribution
    cfg_next = '0; lnk(32, 8, 0); lnk(44, 0, 1);
    for (int s = 0; s < NS; s++) cfg_next[SB + s*NL +: NL] = '0;
    apply(4'h0, 4'h0, 8'h01, "R9");
    apply(4'h1, 4'h0, 8'h00, "R9");
    // R10 member that also links the feedback
    cfg_next = '0; lnk(6, 3, 0); cfg_next[6*TW + 33] = 1; cfg_next[6*TW + 32] = 1;
    cfg_next[SB + 6*NL + 6] = 1;
    apply(4'h8, 4'h0, 8'h00, "R10");
    apply(4'h0, 4'h0, 8'h00, "R10");
    // R5 random sparse configurations
    for (int n = 0; n < 300; n++) begin
      cfg_next = '0;
      for (int i = 0; i < SB; i++) if ($urandom % 24 == 0) cfg_next[i] = 1;
      for (int i = SB; i < CW; i++) if ($urandom % 4 == 0) cfg_next[i] = 1;
      apply(4'($urandom), 4'($urandom), 8'($urandom), "R5");
    end
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    cfg = '0; cfg_next = '0; din = 0; pin = 0; fb = 0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule